// File: doc/BRIEF.md
# Triggered I2C Master Byte Engine

This block is an I2C master that carries out exactly one bus phase each time it is triggered. The host picks a phase with a 3-bit operation code and pulses a trigger. The phase can be a start condition, a stop condition, an outgoing byte, an incoming byte, an outgoing ACK or NAK bit, or an incoming acknowledge bit. The engine then runs the phase on the wires. When it finishes it raises a completion flag and a 3-bit status code that names the phase that just ended. For an incoming acknowledge bit, the code also says whether an ACK or a NAK was seen.

The open-drain lines appear as two drive-low enables plus the sampled SDA level. The bit timing comes from a fixed divider, `CLK_DIV` system clocks per quarter bit. Incoming bytes pass through a shift register and then a one-byte receive buffer, so two unread bytes can be held at once. If a transmit or receive trigger arrives while both of those places are full, a sticky overrun flag is set. The completion flag and the overrun flag each drive an interrupt line through their own enable.

Top module: `i2c_op_engine`

## Requirements
- R1: When a phase ends, `statusCode` takes this value: start 0, stop 1, byte sent 2, byte received 3, ACK or NAK sent 4, acknowledge bit read low (ACK) 5, acknowledge bit read high (NAK) 6. The value 7 never appears.
- R2: `doneFlag` rises in the cycle that a triggered phase ends. `doneIrq` is high exactly while `doneFlag` and `doneIrqEn` are both 1.
- R3: A one-cycle pulse on `doneClr` clears `doneFlag` and sets `statusCode` to 0. While `doneClr` stays 0, both hold their values.
- R4: `ovrFlag` is set when a trigger with code 2 or 3 is accepted while the receive buffer and the shift register both hold unread bytes. It is not set when only the buffer holds a byte.
- R5: `ovrFlag` stays set until a pulse on `ovrClr`, whatever else happens (reads, further phases). `errIrq` is high exactly while `ovrFlag` and `errIrqEn` are both 1.
- R6: With two bytes held, the first `rxRead` pulse moves the newer byte into view on `rxData`. Before that pulse, `rxData` shows the older byte.
- R7: Operation codes: 0 start, 1 stop, 2 send byte from `txData`, 3 receive byte, 4 send ACK, 5 send NAK, 6 read acknowledge bit. Bytes go out MSB first. SDA (`sdaLowEn`) changes while SCL is released only during start and stop.
- R8: A start is SDA falling while SCL is high, and the bus stays held afterwards. A stop is SDA rising while SCL is high, and it leaves both lines released.
- R9: A received byte is assembled MSB first from `sdaIn`. When the phase ends, the byte goes to the buffer if the buffer is empty. Otherwise it stays in the shift register.
- R10: A trigger that arrives while `busy` is 1 is ignored, and so is a trigger with code 7. Neither starts a phase nor changes the status.
- R11: After reset, `busy`, `doneFlag`, `statusCode`, `ovrFlag`, `sclLowEn` and `sdaLowEn` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| trigValid | input | 1 | One-cycle trigger pulse |
| trigOp | input | 3 | Operation code for the trigger |
| txData | input | 8 | Byte to send, taken at the trigger |
| rxRead | input | 1 | Pulse: consume the byte shown on rxData |
| rxData | output | 8 | Receive buffer contents |
| doneClr | input | 1 | Pulse: clear completion flag and status |
| ovrClr | input | 1 | Pulse: clear overrun flag |
| doneIrqEn | input | 1 | Completion interrupt enable |
| errIrqEn | input | 1 | Overrun interrupt enable |
| busy | output | 1 | A phase is running |
| doneFlag | output | 1 | Completion flag |
| statusCode | output | 3 | Code of the last finished phase |
| ovrFlag | output | 1 | Overrun flag |
| doneIrq | output | 1 | Completion interrupt |
| errIrq | output | 1 | Overrun interrupt |
| sdaIn | input | 1 | Sampled SDA line level |
| sclLowEn | output | 1 | Pull SCL low |
| sdaLowEn | output | 1 | Pull SDA low |

## Verification
A full transaction is walked phase by phase from a table. The outgoing bytes 0xA5 and 0x3C have alternating and grouped bit runs, so a reversed bit order or an extra shift would show up. The incoming bytes 0x96 and 0x5A do the same for the receive path. Acknowledge bits are read both low and high, which separates codes 5 and 6. Directed runs then fill the buffer and the shift register without reads. They check that the first of these triggers, with only the buffer full, does not set overrun, that the one after it does, and that the drain order is correct. They also send a trigger during a busy phase and one with code 7, and watch the bus for start and stop edges to confirm neither has any effect.

// File: rtl/i2c_op_pkg.sv
package i2c_op_pkg;

  typedef enum logic [2:0] {
    OP_START = 3'd0,
    OP_STOP  = 3'd1,
    OP_TX    = 3'd2,
    OP_RX    = 3'd3,
    OP_ACK   = 3'd4,
    OP_NAK   = 3'd5,
    OP_RXACK = 3'd6,
    OP_NONE  = 3'd7
  } op_e;

  localparam logic [2:0] ST_STARTED = 3'd0;
  localparam logic [2:0] ST_STOPPED = 3'd1;
  localparam logic [2:0] ST_TXDONE  = 3'd2;
  localparam logic [2:0] ST_RXDONE  = 3'd3;
  localparam logic [2:0] ST_ACKSENT = 3'd4;
  localparam logic [2:0] ST_ACKGOT  = 3'd5;
  localparam logic [2:0] ST_NAKGOT  = 3'd6;

  typedef struct packed {
    logic loadTx;
    logic shiftTx;
    logic sampleBit;
    logic commitRx;
    logic checkOvr;
  } dp_strobe_t;

endpackage

// File: rtl/i2c_op_ctrl.sv
module i2c_op_ctrl
  import i2c_op_pkg::*;
#(
  parameter int CLK_DIV = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       trigValid,
  input  logic [2:0] trigOp,
  input  logic       doneClr,
  input  logic       doneIrqEn,
  input  logic       sdaIn,
  input  logic       txBit,
  output dp_strobe_t strb,
  output logic       busy,
  output logic       doneFlag,
  output logic [2:0] statusCode,
  output logic       doneIrq,
  output logic       sclLowEn,
  output logic       sdaLowEn
);

  localparam int DIV_W = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(CLK_DIV - 1);

  logic             running;
  op_e              curOp;
  logic [1:0]       quarter;
  logic [DIV_W-1:0] divCnt;
  logic [2:0]       bitCnt;
  logic             lineHeld;
  logic             sdaHeld;
  logic             ackBit;

  logic accept, quarterEnd, bitEnd, opEnd, sampleNow, isByteOp;
  logic sclDrive, sdaDrive, bitDrive;
  logic [2:0] doneCode;

  assign isByteOp   = (trigOp == OP_TX) || (trigOp == OP_RX);
  assign accept     = trigValid && !running && (trigOp != OP_NONE);
  assign quarterEnd = running && (divCnt == DIV_LAST);
  assign bitEnd     = quarterEnd && (quarter == 2'd3);
  assign opEnd      = bitEnd && (bitCnt == 3'd0);
  assign sampleNow  = quarterEnd && (quarter == 2'd1);

  always_comb begin
    case (curOp)
      OP_TX:   bitDrive = ~txBit;
      OP_ACK:  bitDrive = 1'b1;
      default: bitDrive = 1'b0;
    endcase
  end

  always_comb begin
    sclDrive = lineHeld;
    sdaDrive = sdaHeld;
    if (running) begin
      case (curOp)
        OP_START: begin
          sclDrive = (quarter == 2'd0) ? lineHeld : (quarter == 2'd3);
          sdaDrive = quarter[1];
        end
        OP_STOP: begin
          sclDrive = (quarter == 2'd0);
          sdaDrive = !quarter[1];
        end
        default: begin
          sclDrive = (quarter == 2'd0) || (quarter == 2'd3);
          sdaDrive = bitDrive;
        end
      endcase
    end
  end

  always_comb begin
    case (curOp)
      OP_START: doneCode = ST_STARTED;
      OP_STOP:  doneCode = ST_STOPPED;
      OP_TX:    doneCode = ST_TXDONE;
      OP_RX:    doneCode = ST_RXDONE;
      OP_RXACK: doneCode = ackBit ? ST_NAKGOT : ST_ACKGOT;
      default:  doneCode = ST_ACKSENT;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      running    <= 1'b0;
      curOp      <= OP_START;
      quarter    <= 2'd0;
      divCnt     <= '0;
      bitCnt     <= 3'd0;
      lineHeld   <= 1'b0;
      sdaHeld    <= 1'b0;
      ackBit     <= 1'b0;
      doneFlag   <= 1'b0;
      statusCode <= ST_STARTED;
    end else begin
      if (accept) begin
        running <= 1'b1;
        curOp   <= op_e'(trigOp);
        quarter <= 2'd0;
        divCnt  <= '0;
        bitCnt  <= isByteOp ? 3'd7 : 3'd0;
      end else if (running) begin
        if (quarterEnd) begin
          divCnt  <= '0;
          quarter <= quarter + 2'd1;
        end else begin
          divCnt <= divCnt + 1'b1;
        end
        if (bitEnd) bitCnt <= bitCnt - 3'd1;
        if (sampleNow && curOp == OP_RXACK) ackBit <= sdaIn;
        if (opEnd) begin
          running  <= 1'b0;
          lineHeld <= (curOp != OP_STOP);
          sdaHeld  <= sdaDrive;
        end
      end
      if (opEnd) begin
        doneFlag   <= 1'b1;
        statusCode <= doneCode;
      end else if (doneClr) begin
        doneFlag   <= 1'b0;
        statusCode <= ST_STARTED;
      end
    end
  end

  always_comb begin
    strb           = '0;
    strb.loadTx    = accept;
    strb.shiftTx   = bitEnd && (curOp == OP_TX);
    strb.sampleBit = sampleNow && (curOp == OP_RX);
    strb.commitRx  = opEnd && (curOp == OP_RX);
    strb.checkOvr  = accept && isByteOp;
  end

  assign busy     = running;
  assign doneIrq  = doneFlag && doneIrqEn;
  assign sclLowEn = sclDrive;
  assign sdaLowEn = sdaDrive;

  // R1: code 7 is never reported
  p_code_valid_r1: assert property (@(posedge clk) disable iff (!rstN)
    doneFlag |-> (statusCode != 3'd7));

  // R2: the flag only rises from a running phase
  p_done_src_r2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(doneFlag) |-> $past(running));

  // R3: a clear with no completion empties flag and status
  p_clear_r3: assert property (@(posedge clk) disable iff (!rstN)
    (doneClr && !opEnd) |=> (!doneFlag && statusCode == 3'd0));

  // R7: SDA moves under released SCL only during start or stop
  p_sda_scl_high_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!sclLowEn && !$past(sclLowEn) && (sdaLowEn != $past(sdaLowEn)))
      |-> (running && (curOp == OP_START || curOp == OP_STOP)));

  // R10: a trigger during a running phase leaves the operation alone
  p_busy_ignore_r10: assert property (@(posedge clk) disable iff (!rstN)
    (running && trigValid) |=> (curOp == $past(curOp)));

endmodule

// File: rtl/i2c_op_dpath.sv
module i2c_op_dpath
  import i2c_op_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  dp_strobe_t        strb,
  input  logic [DATA_W-1:0] txData,
  input  logic              sdaIn,
  input  logic              rxRead,
  input  logic              ovrClr,
  input  logic              errIrqEn,
  output logic              txBit,
  output logic [DATA_W-1:0] rxData,
  output logic              ovrFlag,
  output logic              errIrq
);

  logic [DATA_W-1:0] txShift, rxShift, rxBuf, bufNext;
  logic bufFull, shiftFull, bufFullNext, shiftFullNext;

  always_comb begin
    bufNext       = rxBuf;
    bufFullNext   = bufFull;
    shiftFullNext = shiftFull;
    if (rxRead && bufFull) begin
      if (shiftFull) begin
        bufNext       = rxShift;
        shiftFullNext = 1'b0;
      end else begin
        bufFullNext = 1'b0;
      end
    end
    if (strb.commitRx) begin
      if (!bufFullNext) begin
        bufNext     = rxShift;
        bufFullNext = 1'b1;
      end else begin
        shiftFullNext = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txShift   <= '0;
      rxShift   <= '0;
      rxBuf     <= '0;
      bufFull   <= 1'b0;
      shiftFull <= 1'b0;
      ovrFlag   <= 1'b0;
    end else begin
      if (strb.loadTx)       txShift <= txData;
      else if (strb.shiftTx) txShift <= {txShift[DATA_W-2:0], 1'b0};
      if (strb.sampleBit)    rxShift <= {rxShift[DATA_W-2:0], sdaIn};
      rxBuf     <= bufNext;
      bufFull   <= bufFullNext;
      shiftFull <= shiftFullNext;
      if (strb.checkOvr && bufFull && shiftFull) ovrFlag <= 1'b1;
      else if (ovrClr)                           ovrFlag <= 1'b0;
    end
  end

  assign txBit  = txShift[DATA_W-1];
  assign rxData = rxBuf;
  assign errIrq = ovrFlag && errIrqEn;

  // R4: overrun only from a byte trigger with both places full
  p_ovr_cause_r4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ovrFlag) |-> $past(strb.checkOvr && bufFull && shiftFull));

  // R5: overrun stays until cleared
  p_ovr_sticky_r5: assert property (@(posedge clk) disable iff (!rstN)
    (ovrFlag && !ovrClr) |=> ovrFlag);

  // R9: the shift register only holds a byte behind a full buffer
  p_shift_behind_buf_r9: assert property (@(posedge clk) disable iff (!rstN)
    shiftFull |-> bufFull);

endmodule

// File: rtl/i2c_op_engine.sv
module i2c_op_engine
  import i2c_op_pkg::*;
#(
  parameter int CLK_DIV = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       trigValid,
  input  logic [2:0] trigOp,
  input  logic [7:0] txData,
  input  logic       rxRead,
  output logic [7:0] rxData,
  input  logic       doneClr,
  input  logic       ovrClr,
  input  logic       doneIrqEn,
  input  logic       errIrqEn,
  output logic       busy,
  output logic       doneFlag,
  output logic [2:0] statusCode,
  output logic       ovrFlag,
  output logic       doneIrq,
  output logic       errIrq,
  input  logic       sdaIn,
  output logic       sclLowEn,
  output logic       sdaLowEn
);

  dp_strobe_t strb;
  logic       txBit;

  i2c_op_ctrl #(.CLK_DIV(CLK_DIV)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .trigValid  (trigValid),
    .trigOp     (trigOp),
    .doneClr    (doneClr),
    .doneIrqEn  (doneIrqEn),
    .sdaIn      (sdaIn),
    .txBit      (txBit),
    .strb       (strb),
    .busy       (busy),
    .doneFlag   (doneFlag),
    .statusCode (statusCode),
    .doneIrq    (doneIrq),
    .sclLowEn   (sclLowEn),
    .sdaLowEn   (sdaLowEn)
  );

  i2c_op_dpath #(.DATA_W(8)) u_dpath (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .txData   (txData),
    .sdaIn    (sdaIn),
    .rxRead   (rxRead),
    .ovrClr   (ovrClr),
    .errIrqEn (errIrqEn),
    .txBit    (txBit),
    .rxData   (rxData),
    .ovrFlag  (ovrFlag),
    .errIrq   (errIrq)
  );

endmodule

// File: tb/i2c_op_engine_bench.sv
module i2c_op_engine_bench;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;
  localparam int NVEC       = 10;

  // vector: {op[2:0], data[7:0], expected status[2:0]}
  localparam logic [13:0] VECS [NVEC] = '{
    {3'd0, 8'h00, 3'd0},
    {3'd2, 8'hA5, 3'd2},
    {3'd6, 8'h00, 3'd5},
    {3'd2, 8'h3C, 3'd2},
    {3'd6, 8'h01, 3'd6},
    {3'd3, 8'h96, 3'd3},
    {3'd4, 8'h00, 3'd4},
    {3'd3, 8'h5A, 3'd3},
    {3'd5, 8'h00, 3'd4},
    {3'd1, 8'h00, 3'd1}
  };

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       trigValid = 1'b0;
  logic [2:0] trigOp = 3'd0;
  logic [7:0] txData = 8'h00;
  logic       rxRead = 1'b0;
  logic       doneClr = 1'b0;
  logic       ovrClr = 1'b0;
  logic       doneIrqEn = 1'b0;
  logic       errIrqEn = 1'b0;
  logic [7:0] rxData;
  logic       busy, doneFlag, ovrFlag, doneIrq, errIrq;
  logic [2:0] statusCode;
  logic       sclLowEn, sdaLowEn;

  logic       slvDrive = 1'b0;
  logic [7:0] slvReg = 8'h00;
  int         slvLeft = 0;
  logic [7:0] capByte = 8'h00;
  int         startCnt = 0;
  int         stopCnt = 0;
  int         nChecks = 0;
  int         nFails = 0;
  int         cycles = 0;
  bit         finished = 1'b0;

  wire sclLine = ~sclLowEn;
  wire sdaLine = ~(sdaLowEn | slvDrive);

  i2c_op_engine #(.CLK_DIV(4)) u_i2c_op_engine (
    .clk(clk), .rstN(rstN), .trigValid(trigValid), .trigOp(trigOp),
    .txData(txData), .rxRead(rxRead), .rxData(rxData), .doneClr(doneClr),
    .ovrClr(ovrClr), .doneIrqEn(doneIrqEn), .errIrqEn(errIrqEn),
    .busy(busy), .doneFlag(doneFlag), .statusCode(statusCode),
    .ovrFlag(ovrFlag), .doneIrq(doneIrq), .errIrq(errIrq),
    .sdaIn(sdaLine), .sclLowEn(sclLowEn), .sdaLowEn(sdaLowEn)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // bus monitor
  always @(negedge sdaLine) if (sclLine === 1'b1) startCnt++;
  always @(posedge sdaLine) if (sclLine === 1'b1) stopCnt++;
  always @(posedge sclLine) capByte = {capByte[6:0], sdaLine};

  // slave transmitter: next bit after each SCL fall
  always @(negedge sclLine) begin
    if (slvLeft > 0) begin
      slvLeft--;
      slvReg = {slvReg[6:0], 1'b0};
      slvDrive = (slvLeft != 0) ? ~slvReg[7] : 1'b0;
    end
  end

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG && !finished) begin
      finished = 1'b1;
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual %0d expected below %0d cycles", cycles, WATCHDOG);
      summary();
      $finish;
    end
  end

  task automatic slavePrep(input logic [7:0] val, input int nbits);
    slvReg   = val;
    slvLeft  = nbits;
    slvDrive = ~val[7];
  endtask

  task automatic trigger(input logic [2:0] op, input logic [7:0] data);
    @(negedge clk);
    trigOp = op; txData = data; trigValid = 1'b1;
    @(negedge clk);
    trigValid = 1'b0;
  endtask

  task automatic waitIdle();
    while (busy) @(negedge clk);
  endtask

  task automatic runOp(input logic [2:0] op, input logic [7:0] data);
    trigger(op, data);
    waitIdle();
  endtask

  task automatic pulseRead();
    @(negedge clk); rxRead = 1'b1;
    @(negedge clk); rxRead = 1'b0;
  endtask

  task automatic pulseDoneClr();
    @(negedge clk); doneClr = 1'b1;
    @(negedge clk); doneClr = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    startCnt = 0; stopCnt = 0;

    // R11 reset state
    chk("R11 busy", {7'd0, busy}, 8'd0);
    chk("R11 doneFlag", {7'd0, doneFlag}, 8'd0);
    chk("R11 statusCode", {5'd0, statusCode}, 8'd0);
    chk("R11 ovrFlag", {7'd0, ovrFlag}, 8'd0);
    chk("R11 bus drives", {6'd0, sclLowEn, sdaLowEn}, 8'd0);

    // table-driven transaction
    for (int i = 0; i < NVEC; i++) begin
      logic [2:0] op;
      logic [7:0] dat;
      logic [2:0] expSt;
      {op, dat, expSt} = VECS[i];
      if (op == 3'd3) slavePrep(dat, 8);
      if (op == 3'd6) slavePrep({dat[0], 7'd0}, 1);
      runOp(op, dat);
      chk("R1 status", {5'd0, statusCode}, {5'd0, expSt});
      chk("R2 doneFlag set", {7'd0, doneFlag}, 8'd1);
      if (op == 3'd2) chk("R7 byte on SDA msb first", capByte, dat);
      if (op == 3'd3) begin
        chk("R9 received byte", rxData, dat);
        pulseRead();
      end
      repeat (3) @(negedge clk);
      chk("R3 flag held without clear", {7'd0, doneFlag}, 8'd1);
      pulseDoneClr();
      chk("R3 flag cleared", {7'd0, doneFlag}, 8'd0);
      chk("R3 status zeroed", {5'd0, statusCode}, 8'd0);
    end
    chk("R8 one start edge", 8'(startCnt), 8'd1);
    chk("R8 one stop edge", 8'(stopCnt), 8'd1);
    chk("R8 released after stop", {6'd0, sclLowEn, sdaLowEn}, 8'd0);

    // R2 interrupt gating
    runOp(3'd0, 8'h00);
    chk("R2 irq masked", {7'd0, doneIrq}, 8'd0);
    doneIrqEn = 1'b1;
    #1;
    chk("R2 irq enabled", {7'd0, doneIrq}, 8'd1);
    pulseDoneClr();
    chk("R2 irq follows flag", {7'd0, doneIrq}, 8'd0);
    doneIrqEn = 1'b0;

    // R10 trigger during busy is ignored
    trigger(3'd2, 8'hC3);
    repeat (20) @(negedge clk);
    trigOp = 3'd1; trigValid = 1'b1;
    @(negedge clk);
    trigValid = 1'b0;
    waitIdle();
    repeat (4) @(negedge clk);
    chk("R10 busy trigger dropped status", {5'd0, statusCode}, 8'd2);
    chk("R10 busy trigger no stop", 8'(stopCnt), 8'd1);
    chk("R10 byte intact", capByte, 8'hC3);
    chk("R10 no further phase", {7'd0, busy}, 8'd0);
    pulseDoneClr();

    // R10 code 7 is ignored
    trigger(3'd7, 8'h00);
    chk("R10 code7 not busy", {7'd0, busy}, 8'd0);
    repeat (5) @(negedge clk);
    chk("R10 code7 no completion", {7'd0, doneFlag}, 8'd0);

    // R4 R5 R6 overrun and drain
    slavePrep(8'h11, 8);
    runOp(3'd3, 8'h00);
    slavePrep(8'h22, 8);
    runOp(3'd3, 8'h00);
    chk("R4 no overrun with one held", {7'd0, ovrFlag}, 8'd0);
    chk("R9 older byte kept in buffer", rxData, 8'h11);
    runOp(3'd2, 8'h00);
    chk("R4 overrun on trigger with two held", {7'd0, ovrFlag}, 8'd1);
    chk("R5 err irq masked", {7'd0, errIrq}, 8'd0);
    errIrqEn = 1'b1;
    #1;
    chk("R5 err irq enabled", {7'd0, errIrq}, 8'd1);
    chk("R6 older byte first", rxData, 8'h11);
    pulseRead();
    chk("R5 overrun survives read", {7'd0, ovrFlag}, 8'd1);
    chk("R6 newer byte second", rxData, 8'h22);
    @(negedge clk); ovrClr = 1'b1;
    @(negedge clk); ovrClr = 1'b0;
    chk("R5 overrun cleared", {7'd0, ovrFlag}, 8'd0);
    chk("R5 err irq dropped", {7'd0, errIrq}, 8'd0);
    pulseRead();
    slavePrep(8'h33, 8);
    runOp(3'd3, 8'h00);
    chk("R9 empty buffer takes byte", rxData, 8'h33);
    chk("R4 no overrun after drain", {7'd0, ovrFlag}, 8'd0);
    pulseRead();
    runOp(3'd1, 8'h00);
    chk("R8 bus released", {6'd0, sclLowEn, sdaLowEn}, 8'd0);

    finished = 1'b1;
    summary();
    $finish;
  end

endmodule